// File: doc/BRIEF.md
# Gated Nine-Output Clock Fan-Out

This block fans a single reference clock out to nine output pairs, each pair carrying a true copy and a complement copy of the clock. Every pair has its own gate. A gate is open only when the pair's hardware enable pin, its bit in a small control register file and the power-good/power-down input are all high. Some enable pins are shared: one pin serves two pairs, and another serves three.

Gate changes are retimed on the falling edge of the reference clock through a two-stage synchronizer, so pins and register bits may change at any moment. When a gate closes, the true copy is cut while it is low. The complement finishes its current low-phase pulse and is cut at the following rising edge, so the pair comes to rest at low/low. When a gate reopens, the true copy starts with a full high phase and the complement follows in the next low phase. No runt pulse appears in either case.

The power input holds every pair at low/low until it first goes high. After that it works as a live active-low power-down. Two control bytes sit behind a byte-wide write port with a combinational read port.

Top module: `clk_fanout_gate`

## Requirements
- R1: After reset, control byte 1 reads 0xD4 and control byte 2 reads 0x3B, which sets every mapped enable bit to 1. With all pins high and the power input high, all nine pairs toggle.
- R2: Pair i runs only while its pin, its register bit and the power input are all high. Otherwise both of its signals rest low.
- R3: oe_pin[0..3] drive pairs 0..3. oe_pin[4] drives pairs 4 and 5. oe_pin[5] drives pairs 6, 7 and 8.
- R4: Register enable bits, written as byte:bit, map to pairs as follows: 1:4 to pair 0, 1:2 to pair 1, 2:1 to pair 2, 2:0 to pair 3, 1:7 to pair 4, 1:6 to pair 5, 2:5 to pair 6, 2:4 to pair 7, 2:3 to pair 8.
- R5: If an enable input is low at two successive falling edges, the true copy shows no high phase after the second of those edges. The complement ends low at the next rising edge, and the pair stays at low/low.
- R6: A reopened pair restarts with a complete high phase on the true copy. The complement restarts in the low phase that follows. The two copies are never high together.
- R7: Before the power input is first high, every pair rests at low/low. After that, a low level on the power input stops every pair under the same timing as R5.
- R8: A write with reg_we high at a rising edge of ref_clk stores reg_wdata into byte 1 (address 1) or byte 2 (address 2). Other addresses ignore writes and read 0. Unmapped bits of bytes 1 and 2 read back the value last written and have no effect on any pair.
- R9: A change to the enable of one pair never alters the waveform of any other pair.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| ref_clk | input | 1 | Reference clock that is fanned out |
| rst_n | input | 1 | Asynchronous active-low reset |
| pg_pd | input | 1 | Power-good, then live active-low power-down |
| oe_pin | input | 6 | Hardware enable pins (grouped per R3) |
| reg_addr | input | 8 | Register address |
| reg_wdata | input | 8 | Register write data |
| reg_we | input | 1 | Register write strobe |
| reg_rdata | output | 8 | Combinational register read data |
| clk_p | output | 9 | True clock copies, one per pair |
| clk_n | output | 9 | Complement clock copies, one per pair |

## Verification
Two events can land on the same clock: a register write that closes one pair, and a pin change that reopens or closes a different pair or group. The power input can also drop in the very cycle a pair is reopening. The bench provokes these collisions with scripted and pseudo-random changes to pins, control bytes and the power input, each applied one nanosecond after a rising edge. A reference model driven only by those inputs predicts every pair's level in every half cycle, and each high and low phase is compared against that prediction. A missed stop, a late restart or disturbance of a neighbouring pair therefore shows up as a mismatch.

// File: rtl/clk_fanout_gate.sv
module clk_fanout_gate #(
  parameter int NUM_OUT = 9,
  parameter int NUM_PIN = 6,
  parameter int AW      = 8,
  parameter int DW      = 8,
  parameter logic [DW-1:0] RST_B1 = 8'hD4,
  parameter logic [DW-1:0] RST_B2 = 8'h3B
) (
  input  logic               ref_clk,
  input  logic               rst_n,
  input  logic               pg_pd,
  input  logic [NUM_PIN-1:0] oe_pin,
  input  logic [AW-1:0]      reg_addr,
  input  logic [DW-1:0]      reg_wdata,
  input  logic               reg_we,
  output logic [DW-1:0]      reg_rdata,
  output logic [NUM_OUT-1:0] clk_p,
  output logic [NUM_OUT-1:0] clk_n
);

  localparam logic [AW-1:0] ADDR_B1 = AW'(1);
  localparam logic [AW-1:0] ADDR_B2 = AW'(2);

  function automatic int map_byte(input int i);
    case (i)
      0, 1, 4, 5: return 1;
      default:    return 2;
    endcase
  endfunction

  function automatic int map_bit(input int i);
    case (i)
      0: return 4;
      1: return 2;
      2: return 1;
      3: return 0;
      4: return 7;
      5: return 6;
      6: return 5;
      7: return 4;
      default: return 3;
    endcase
  endfunction

  function automatic int map_pin(input int i);
    if (i < 4)      return i;
    else if (i < 6) return 4;
    else            return 5;
  endfunction

  logic [DW-1:0]      ctl1, ctl2;
  logic [NUM_OUT-1:0] raw_en, sync_q, gate_p, gate_n;

  always_ff @(posedge ref_clk or negedge rst_n)
    if (!rst_n) begin
      ctl1 <= RST_B1;
      ctl2 <= RST_B2;
    end else if (reg_we) begin
      if (reg_addr == ADDR_B1) ctl1 <= reg_wdata;
      if (reg_addr == ADDR_B2) ctl2 <= reg_wdata;
    end

  assign reg_rdata = (reg_addr == ADDR_B1) ? ctl1 :
                     (reg_addr == ADDR_B2) ? ctl2 : '0;

  for (genvar i = 0; i < NUM_OUT; i++) begin : g_out
    localparam int BY = map_byte(i);
    localparam int BI = map_bit(i);
    localparam int PI = map_pin(i);
    logic reg_bit;
    if (BY == 1) begin : g_b1
      assign reg_bit = ctl1[BI];
    end else begin : g_b2
      assign reg_bit = ctl2[BI];
    end
    assign raw_en[i] = reg_bit & oe_pin[PI] & pg_pd;
  end

  always_ff @(negedge ref_clk or negedge rst_n)
    if (!rst_n) begin
      sync_q <= '0;
      gate_p <= '0;
    end else begin
      sync_q <= raw_en;
      gate_p <= sync_q;
    end

  always_ff @(posedge ref_clk or negedge rst_n)
    if (!rst_n) gate_n <= '0;
    else        gate_n <= gate_p;

  assign clk_p = {NUM_OUT{ref_clk}}  & gate_p;
  assign clk_n = {NUM_OUT{~ref_clk}} & gate_n;

endmodule

module clk_fanout_gate_chk (
  input logic       ref_clk,
  input logic       rst_n,
  input logic       pg_pd,
  input logic [5:0] oe_pin,
  input logic [7:0] reg_addr,
  input logic [7:0] reg_wdata,
  input logic       reg_we,
  input logic [7:0] ctl1,
  input logic [7:0] ctl2,
  input logic [8:0] clk_p
);
  // R7
  pwrdn_stops_chk: assert property (@(negedge ref_clk) disable iff (!rst_n)
    (!$past(pg_pd) && !$past(pg_pd, 2)) |-> (clk_p == '0));
  // R3
  group_pin_chk: assert property (@(negedge ref_clk) disable iff (!rst_n)
    (!$past(oe_pin[5]) && !$past(oe_pin[5], 2)) |-> (clk_p[8:6] == '0));
  // R8
  wr_b1_chk: assert property (@(posedge ref_clk) disable iff (!rst_n)
    (reg_we && reg_addr == 8'd1) |=> (ctl1 == $past(reg_wdata)));
  // R8
  wr_other_chk: assert property (@(posedge ref_clk) disable iff (!rst_n)
    (reg_we && reg_addr != 8'd1 && reg_addr != 8'd2) |=> ($stable(ctl1) && $stable(ctl2)));
  // R2
  pin0_off_chk: assert property (@(negedge ref_clk) disable iff (!rst_n)
    (!$past(oe_pin[0]) && !$past(oe_pin[0], 2)) |-> (clk_p[0] == 1'b0));
endmodule

bind clk_fanout_gate clk_fanout_gate_chk chk_i (
  .ref_clk(ref_clk), .rst_n(rst_n), .pg_pd(pg_pd), .oe_pin(oe_pin),
  .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_we(reg_we),
  .ctl1(ctl1), .ctl2(ctl2), .clk_p(clk_p)
);

// File: tb/clk_fanout_gate_tb_top.sv
`timescale 1ns/1ps
module clk_fanout_gate_tb_top;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       pg;
  logic [5:0] oe;
  logic [7:0] addr, wdata, rdata;
  logic       we;
  logic [8:0] p, n;

  int checks = 0, fails = 0;
  string cur_req = "R1";
  bit done = 0;

  clk_fanout_gate dut_i (
    .ref_clk(clk), .rst_n(rst_n), .pg_pd(pg), .oe_pin(oe),
    .reg_addr(addr), .reg_wdata(wdata), .reg_we(we), .reg_rdata(rdata),
    .clk_p(p), .clk_n(n)
  );

  always #5 clk = ~clk;

  logic [7:0] m1, m2;
  logic [8:0] mq1, mgp, mgn;

  function automatic logic [8:0] m_raw();
    logic [8:0] r;
    r[0] = oe[0] & m1[4];
    r[1] = oe[1] & m1[2];
    r[2] = oe[2] & m2[1];
    r[3] = oe[3] & m2[0];
    r[4] = oe[4] & m1[7];
    r[5] = oe[4] & m1[6];
    r[6] = oe[5] & m2[5];
    r[7] = oe[5] & m2[4];
    r[8] = oe[5] & m2[3];
    return r & {9{pg}};
  endfunction

  always @(negedge clk or negedge rst_n)
    if (!rst_n) begin mq1 = '0; mgp = '0; end
    else begin mgp = mq1; mq1 = m_raw(); end

  always @(posedge clk or negedge rst_n)
    if (!rst_n) begin mgn = '0; m1 = 8'hD4; m2 = 8'h3B; end
    else begin
      mgn = mgp;
      if (we && addr == 8'd1) m1 = wdata;
      if (we && addr == 8'd2) m2 = wdata;
    end

  task automatic chk9(string what, logic [8:0] act, logic [8:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %b expected %b at %0t", cur_req, what, act, exp, $time);
    end
  endtask

  always @(posedge clk) begin
    #3;
    if (!done) begin chk9("high-phase p", p, mgp); chk9("high-phase n", n, 9'h0); end
  end
  always @(negedge clk) begin
    #3;
    if (!done) begin chk9("low-phase p", p, 9'h0); chk9("low-phase n", n, mgn); end
  end

  task automatic step(int k);
    repeat (k) @(posedge clk);
    #1;
  endtask

  task automatic wr(logic [7:0] a, logic [7:0] d);
    addr = a; wdata = d; we = 1'b1;
    step(1);
    we = 1'b0;
  endtask

  task automatic rd(logic [7:0] a, logic [7:0] exp, string tag);
    addr = a; #1;
    checks++;
    if (rdata !== exp) begin
      fails++;
      $display("FAIL %s read addr %0d: actual %h expected %h", tag, a, rdata, exp);
    end
  endtask

  initial begin
    #(200000 * 10);
    fails++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("[TB] %0d tests run, %0d failed", checks, fails);
    $finish;
  end

  initial begin
    rst_n = 1'b0; pg = 1'b0; oe = 6'h3F; addr = 0; wdata = 0; we = 0;
    step(3);
    rd(8'd1, 8'hD4, "R1");
    rd(8'd2, 8'h3B, "R1");
    rst_n = 1'b1;
    cur_req = "R7";
    step(6);
    chk9("pre-power-good idle", p | n, 9'h0);
    cur_req = "R1";
    pg = 1'b1;
    step(6);
    cur_req = "R3";
    oe[4] = 1'b0; step(5);
    oe[5] = 1'b0; step(5);
    oe[4] = 1'b1; step(5);
    oe = 6'h3F; step(5);
    cur_req = "R5";
    oe[0] = 1'b0; step(6);
    cur_req = "R6";
    oe[0] = 1'b1; step(6);
    cur_req = "R4";
    for (int b = 0; b < 8; b++) begin
      wr(8'd1, 8'hD4 & ~(8'h01 << b)); step(4);
      wr(8'd2, 8'h3B & ~(8'h01 << b)); step(4);
    end
    wr(8'd1, 8'hD4); wr(8'd2, 8'h3B); step(4);
    cur_req = "R8";
    wr(8'd1, 8'hFF); wr(8'd2, 8'hFF); step(4);
    rd(8'd1, 8'hFF, "R8");
    rd(8'd2, 8'hFF, "R8");
    wr(8'd1, 8'h2B); step(4);
    rd(8'd1, 8'h2B, "R8");
    wr(8'd3, 8'h00); wr(8'd0, 8'h00); wr(8'd255, 8'h00); step(3);
    rd(8'd3, 8'h00, "R8");
    rd(8'd0, 8'h00, "R8");
    rd(8'd1, 8'h2B, "R8");
    wr(8'd1, 8'hD4); step(3);
    cur_req = "R7";
    pg = 1'b0; step(6);
    chk9("power-down p", p, 9'h0);
    pg = 1'b1; oe[2] = 1'b0; step(3);
    oe[2] = 1'b1; pg = 1'b0; step(1); pg = 1'b1; step(5);
    cur_req = "R9";
    for (int i = 0; i < 300; i++) begin
      oe = 6'($urandom);
      if (i % 5 == 0) wr(8'd1 + 8'($urandom_range(0, 1)), 8'($urandom));
      if (i % 37 == 0) pg = ~pg;
      step(1 + int'($urandom_range(0, 2)));
    end
    cur_req = "R2";
    pg = 1'b1; oe = 6'h3F; wr(8'd1, 8'hD4); wr(8'd2, 8'h3B); step(5);
    chk9("all running p", p, 9'h1FF);
    step(2);
    done = 1;
    $display("[TB] %0d tests run, %0d failed", checks, fails);
    $finish;
  end
endmodule